// File: doc/BRIEF.md
# PLL Divider Configuration Capture

This block holds the divider settings of a clock synthesizer and can be loaded from either of two paths. The parallel path presents a 9-bit feedback divide value and a 2-bit output-divide code on plain pins. A rising edge on the parallel strobe copies them into the configuration registers. The serial path shifts a 14-bit word in one bit at a time. A falling edge on the serial strobe commits that word. The serial word also carries a 3-bit observation select that steers one internal node onto a single test output.

Every input is sampled by the system clock. The serial clock and both strobes are treated as slow level signals. Each passes through a two-flop synchronizer, and the block acts on the edges it sees after synchronization. The data and strobe pins have no valid/ready handshake and no back-pressure. A host keeps the parallel data and the serial data bit steady while the matching strobe or serial clock edge passes through the synchronizer, which takes a few system cycles. The usual power-up sequence keeps the parallel strobe low through reset and raises it afterwards. That rise performs the first parallel load.

Top module: `pll_cfg_capture`

## Requirements
- R1: While reset is asserted, and just after it is released, the configuration reads feedback divide 200, output-divide code 0 (divide by 1) and observation select 0. The serial shift register is all zeros, so a serial commit made before any shifting loads zeros into all three fields.
- R2: Each rising edge of the serial clock shifts the serial data bit into bit 0 of a 14-bit register, and every older bit moves up one place. The first bit shifted ends up most significant. After 14 shifts, bits 13..11 hold the observation select, bits 10..9 the output-divide code and bits 8..0 the feedback divide. Shifting more than 14 bits keeps only the last 14.
- R3: A rising edge of the parallel strobe while the serial strobe is low loads the parallel feedback divide and output-divide code, and clears the observation select to 0.
- R4: A rising edge of the parallel strobe while the serial strobe is high leaves the configuration unchanged.
- R5: A falling edge of the serial strobe while the parallel strobe is high loads all three fields from the shift register. A falling edge while the parallel strobe is low leaves the configuration unchanged.
- R6: When a qualifying parallel rise and a serial fall are seen in the same cycle, the parallel load wins.
- R7: Apart from the loads in R3, R5 and R6, the configuration holds its value. In particular, serial clock edges do not change it.
- R8: The observation output follows the select code as follows: 0 gives constant 0, 1 gives feedback divide bit 0, 2 gives output-divide code bit 0, 3 gives output-divide code bit 1, 4 gives shift register bit 13, 5 gives the reference-divider input, 6 gives the feedback-divider input, and 7 gives constant 1.
- R9: Suppose a strobe changes just before system clock edge k. The configuration outputs still show the old value after edge k+1 and show the new value after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output-divide code |
| par_ld | input | 1 | Parallel load strobe, acts on its rising edge |
| ser_clk | input | 1 | Serial shift clock, sampled by clk |
| ser_data | input | 1 | Serial data bit |
| ser_ld | input | 1 | Serial commit strobe, acts on its falling edge |
| ref_div_in | input | 1 | Reference-divider node for observation |
| fb_div_in | input | 1 | Feedback-divider node for observation |
| cfg_m | output | 9 | Active feedback divide |
| cfg_n | output | 2 | Active output-divide code |
| cfg_t | output | 3 | Active observation select |
| obs_out | output | 1 | Observation output |

## Verification
The hardest case to reach is the collision in R6. It needs a parallel rise and a serial fall to come out of the synchronizers in the same system cycle, and that only happens when both pins change before the same clock edge. The bench first parks the serial strobe high and the parallel strobe low. Then, in one negedge, it flips both pins together, so both edges reach the load logic in the same cycle. Reaching the shift-register tap in R8 after a load, without another commit, takes one extra serial shift. After that shift, the tap must show the word's second bit while the configuration stays put.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int M_W    = 9;
  localparam int N_W    = 2;
  localparam int T_W    = 3;
  localparam int WORD_W = T_W + N_W + M_W;

  // serial word layout: first-shifted bits land in t, last in m
  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_word_t;

  typedef enum logic [T_W-1:0] {
    OBS_ZERO      = 3'd0,
    OBS_M_LSB     = 3'd1,
    OBS_N_LSB     = 3'd2,
    OBS_N_MSB     = 3'd3,
    OBS_SHIFT_MSB = 3'd4,
    OBS_REF       = 3'd5,
    OBS_FB        = 3'd6,
    OBS_ONE       = 3'd7
  } obs_sel_e;
endpackage

// File: rtl/pll_cfg_sync.sv
module pll_cfg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pll_cfg_shifter.sv
module pll_cfg_shifter #(
  parameter int WIDTH = pll_cfg_pkg::WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {q[WIDTH-2:0], din};
  end
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_cfg_pkg::*;
#(
  parameter int M_RESET = 200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_rise,
  input  logic           par_lvl,
  input  logic           ser_fall,
  input  logic           ser_lvl,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  cfg_word_t      shift_word,
  output cfg_word_t      cfg
);
  logic par_take;
  logic ser_take;

  // parallel path wins any same-cycle collision
  assign par_take = par_rise & ~ser_lvl;
  assign ser_take = ser_fall & par_lvl & ~par_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.t <= '0;
      cfg.n <= '0;
      cfg.m <= M_W'(M_RESET);
    end else if (par_take) begin
      cfg.t <= '0;
      cfg.n <= par_n;
      cfg.m <= par_m;
    end else if (ser_take) begin
      cfg <= shift_word;
    end
  end
endmodule

// File: rtl/pll_cfg_obs_mux.sv
module pll_cfg_obs_mux
  import pll_cfg_pkg::*;
(
  input  cfg_word_t cfg,
  input  logic      shift_msb,
  input  logic      ref_div_in,
  input  logic      fb_div_in,
  output logic      obs_out
);
  obs_sel_e sel;
  assign sel = obs_sel_e'(cfg.t);

  always_comb begin
    unique case (sel)
      OBS_ZERO:      obs_out = 1'b0;
      OBS_M_LSB:     obs_out = cfg.m[0];
      OBS_N_LSB:     obs_out = cfg.n[0];
      OBS_N_MSB:     obs_out = cfg.n[N_W-1];
      OBS_SHIFT_MSB: obs_out = shift_msb;
      OBS_REF:       obs_out = ref_div_in;
      OBS_FB:        obs_out = fb_div_in;
      default:       obs_out = 1'b1;
    endcase
  end
endmodule

// File: rtl/pll_cfg_capture.sv
module pll_cfg_capture
  import pll_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int M_RESET     = 200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           par_ld,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_ld,
  input  logic           ref_div_in,
  input  logic           fb_div_in,
  output logic [M_W-1:0] cfg_m,
  output logic [N_W-1:0] cfg_n,
  output logic [T_W-1:0] cfg_t,
  output logic           obs_out
);
  localparam int NSIG = 4;
  localparam int I_SCLK = 0, I_SLD = 1, I_PLD = 2, I_SDAT = 3;

  logic [NSIG-1:0] raw_in, lvl;
  logic [2:0]      prev;
  logic            sclk_rise, ser_fall, par_rise;
  logic            par_lvl, ser_lvl, sdata_lvl;
  logic [WORD_W-1:0] shreg_q;
  cfg_word_t       cfg;

  assign raw_in = {ser_data, par_ld, ser_ld, ser_clk};

  pll_cfg_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl[I_PLD:I_SCLK];
  end

  assign sclk_rise = lvl[I_SCLK] & ~prev[I_SCLK];
  assign ser_fall  = ~lvl[I_SLD] & prev[I_SLD];
  assign par_rise  = lvl[I_PLD] & ~prev[I_PLD];
  assign ser_lvl   = lvl[I_SLD];
  assign par_lvl   = lvl[I_PLD];
  assign sdata_lvl = lvl[I_SDAT];

  pll_cfg_shifter #(.WIDTH(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise), .din(sdata_lvl), .q(shreg_q)
  );

  pll_cfg_regs #(.M_RESET(M_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .par_rise(par_rise), .par_lvl(par_lvl),
    .ser_fall(ser_fall), .ser_lvl(ser_lvl),
    .par_m(par_m), .par_n(par_n),
    .shift_word(cfg_word_t'(shreg_q)),
    .cfg(cfg)
  );

  pll_cfg_obs_mux u_obs (
    .cfg(cfg), .shift_msb(shreg_q[WORD_W-1]),
    .ref_div_in(ref_div_in), .fb_div_in(fb_div_in), .obs_out(obs_out)
  );

  assign cfg_m = cfg.m;
  assign cfg_n = cfg.n;
  assign cfg_t = cfg.t;
endmodule

// File: rtl/pll_cfg_chk.sv
module pll_cfg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        par_rise,
  input logic        ser_fall,
  input logic        sclk_rise,
  input logic        par_lvl,
  input logic        ser_lvl,
  input logic        sdata_lvl,
  input logic [13:0] shreg_q,
  input logic [8:0]  par_m,
  input logic [1:0]  par_n,
  input logic [8:0]  cfg_m,
  input logic [1:0]  cfg_n,
  input logic [2:0]  cfg_t,
  input logic        ref_div_in,
  input logic        obs_out
);
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shreg_q == {$past(shreg_q[12:0]), $past(sdata_lvl)}); // R2
  AST_PAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (par_rise && !ser_lvl) |=> (cfg_m == $past(par_m) && cfg_n == $past(par_n) && cfg_t == 3'd0)); // R3
  AST_PAR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (par_rise && ser_lvl && !ser_fall) |=> $stable({cfg_m, cfg_n, cfg_t})); // R4
  AST_SER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_fall && par_lvl && !par_rise) |=> {cfg_t, cfg_n, cfg_m} == $past(shreg_q)); // R5
  AST_PAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (par_rise && ser_fall) |=> (cfg_m == $past(par_m) && cfg_t == 3'd0)); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_rise && !ser_fall) |=> $stable({cfg_m, cfg_n, cfg_t})); // R7
  AST_OBS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_t == 3'd7) |-> obs_out); // R8
  AST_OBS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_t == 3'd5) |-> (obs_out == ref_div_in)); // R8
endmodule

bind pll_cfg_capture pll_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .par_rise(par_rise), .ser_fall(ser_fall),
  .sclk_rise(sclk_rise), .par_lvl(par_lvl), .ser_lvl(ser_lvl),
  .sdata_lvl(sdata_lvl), .shreg_q(shreg_q), .par_m(par_m), .par_n(par_n),
  .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .ref_div_in(ref_div_in),
  .obs_out(obs_out)
);

// File: tb/tb_pll_cfg_capture.sv
module tb_pll_cfg_capture;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [8:0] par_m = 0;
  logic [1:0] par_n = 0;
  logic       par_ld = 0, ser_clk = 0, ser_data = 0, ser_ld = 0;
  logic       ref_div_in = 0, fb_div_in = 0;
  logic [8:0] cfg_m;
  logic [1:0] cfg_n;
  logic [2:0] cfg_t;
  logic       obs_out;

  int total = 0;
  int bad = 0;
  int em, en, et;

  always #4 clk = ~clk;

  pll_cfg_capture dut (
    .clk(clk), .rst_n(rst_n), .par_m(par_m), .par_n(par_n), .par_ld(par_ld),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_ld(ser_ld),
    .ref_div_in(ref_div_in), .fb_div_in(fb_div_in),
    .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .obs_out(obs_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_cfg(input string req, input int m, input int n, input int t);
    chk(req, "cfg_m", int'(cfg_m), m);
    chk(req, "cfg_n", int'(cfg_n), n);
    chk(req, "cfg_t", int'(cfg_t), t);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) begin
      ser_data = w[i];
      cyc(3); ser_clk = 1;
      cyc(3); ser_clk = 0;
    end
    cyc(3);
  endtask

  task automatic ser_commit();
    ser_ld = 1; cyc(4);
    ser_ld = 0; cyc(5);
  endtask

  task automatic par_commit(input int m, input int n);
    par_m = 9'(m); par_n = 2'(n);
    ser_ld = 0; par_ld = 0; cyc(4);
    par_ld = 1; cyc(5);
  endtask

  function automatic int obs_exp(input logic [13:0] w, input logic [13:0] sh,
                                 input logic r, input logic f);
    case (w[13:11])
      3'd0: return 0;
      3'd1: return int'(w[0]);
      3'd2: return int'(w[9]);
      3'd3: return int'(w[10]);
      3'd4: return int'(sh[13]);
      3'd5: return int'(r);
      3'd6: return int'(f);
      default: return 1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [13:0] w, b;
    cyc(2);
    chk_cfg("R1", 200, 0, 0);
    cyc(3);
    rst_n = 1;
    cyc(3);
    chk_cfg("R1", 200, 0, 0);
    chk("R1", "obs t=0", int'(obs_out), 0);

    // R9 latency, with the first parallel load (R3)
    par_m = 9'd37; par_n = 2'd2;
    par_ld = 1;
    cyc(1); chk("R9", "m after k", int'(cfg_m), 200);
    cyc(1); chk("R9", "m after k+1", int'(cfg_m), 200);
    cyc(1); chk_cfg("R9", 37, 2, 0);
    cyc(3);

    // R1: shift register empty after reset
    ser_commit();
    chk_cfg("R1", 0, 0, 0);

    // R3 sweep over every feedback value
    for (int m = 0; m < 512; m++) begin
      par_commit(m, m % 4);
      chk_cfg("R3", m, m % 4, 0);
    end
    em = 511; en = 3; et = 0;

    // R2/R5/R7 serial sweep
    for (int t = 0; t < 8; t++) begin
      for (int n = 0; n < 4; n++) begin
        int m = (t * 67 + n * 129 + 3) % 512;
        w = {3'(t), 2'(n), 9'(m)};
        shift_word(w);
        chk_cfg("R7", em, en, et);
        ser_commit();
        chk_cfg("R5", m, n, t);
        em = m; en = n; et = t;
      end
    end

    // R2 over-shift keeps the last 14 bits
    shift_word(14'h2A5B);
    b = {3'd4, 2'd1, 9'd300};
    shift_word(b);
    ser_commit();
    chk_cfg("R2", 300, 1, 4);
    chk("R8", "obs tap after load", int'(obs_out), int'(b[13]));
    ser_data = 0; cyc(3); ser_clk = 1; cyc(3); ser_clk = 0; cyc(3);
    chk("R8", "obs tap after extra shift", int'(obs_out), int'(b[12]));
    chk_cfg("R7", 300, 1, 4);

    // R5 serial fall with parallel strobe low is ignored
    par_ld = 0; cyc(4);
    ser_commit();
    chk_cfg("R5", 300, 1, 4);

    // R4 parallel rise with serial strobe high is ignored
    ser_ld = 1; cyc(4);
    par_m = 9'd11; par_n = 2'd3;
    par_ld = 1; cyc(5);
    chk_cfg("R4", 300, 1, 4);
    ser_ld = 0; cyc(5);
    w = {b[12:0], 1'b0};
    chk_cfg("R5", int'(w[8:0]), int'(w[10:9]), int'(w[13:11]));

    // R6 simultaneous edges: parallel wins
    par_ld = 0; ser_ld = 1; cyc(4);
    par_m = 9'd77; par_n = 2'd1;
    par_ld = 1; ser_ld = 0; cyc(5);
    chk_cfg("R6", 77, 1, 0);

    // R8 sweep of the observation select
    for (int t = 0; t < 8; t++) begin
      int m = (t * 37 + 1) % 512;
      w = {3'(t), 2'(t % 4), 9'(m)};
      shift_word(w);
      ser_commit();
      for (int rf = 0; rf < 4; rf++) begin
        ref_div_in = rf[0]; fb_div_in = rf[1];
        cyc(1);
        chk("R8", $sformatf("obs t=%0d rf=%0d", t, rf), int'(obs_out),
            obs_exp(w, w, rf[0], rf[1]));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule